// File: doc/BRIEF.md
# ISA Bus Cycle Generator

This block runs a single ISA bus cycle for a host or wide-bus master, timed by the ISA bus clock. A requester gives a one-clock start strobe together with an address and two attribute bits: memory or I/O, and write or read. The block then steps through address time. It raises the address latch enable for one clock and presents the low address bits on the ISA address outputs. Once that clock is over, those bits are held.

In data time it asserts exactly one of four active-low command strobes. Which one depends on the cycle type. A memory cycle aimed at the first megabyte also asserts the matching standard-memory strobe. A default ready timer decides how long the command lasts. A slave can end the command early with its no-wait-state input, or keep it alive for as long as it needs by pulling channel ready low. When the command ends, the block returns a one-clock ready pulse to the requester, and a new start is only accepted after that.

Top module: `isa_cycle_gen`

## Requirements
- R1: While reset is held, every command strobe and standard-memory strobe is high (inactive), the address latch enable is low and ready is low.
- R2: The start is accepted on the edge at which it is high while idle. The address latch enable is high during the second clock after that edge and for that clock only, and no command strobe is active while it is high.
- R3: While the address latch enable is high, the address outputs carry bits [SA_W-1:0] of the accepted address. These outputs keep that value from then until the next cycle's latch enable.
- R4: During data time exactly one strobe is low, chosen by {memory, write}: 00 I/O read, 01 I/O write, 10 memory read, 11 memory write. It stays the same for the whole command. Outside data time all four are high.
- R5: The standard memory read or write strobe goes low together with the memory read or write strobe only when the address is below 2^LOW_MEG_BITS (0x100000 by default). It never goes low for I/O cycles or for higher addresses.
- R6: With no-wait-state inactive and channel ready high, the command lasts exactly WAIT_STATES+1 clocks.
- R7: No-wait-state low, sampled at the end of a command clock while channel ready is high, makes that clock the last one of the command.
- R8: While channel ready is sampled low the command cannot end. It ends at the first command clock n, counted from 0, in which channel ready is high and either n >= WAIT_STATES or no-wait-state is low.
- R9: Ready is high for exactly one clock, namely the clock right after the last command clock. All strobes are inactive in that clock.
- R10: A start that arrives while a cycle is in progress, including the ready clock, is ignored. It produces no latch enable, no strobe and no ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ISA bus clock |
| rst_ni | input | 1 | Active-low reset |
| start_i | input | 1 | Start strobe for one cycle |
| addr_i | input | ADDR_W | Cycle address |
| write_i | input | 1 | 1 = write, 0 = read |
| mem_i | input | 1 | 1 = memory, 0 = I/O |
| ready_o | output | 1 | One-clock completion pulse |
| bale_o | output | 1 | Address latch enable |
| sa_o | output | SA_W | Latched low address bits |
| iorc_n_o | output | 1 | I/O read command, active low |
| iowc_n_o | output | 1 | I/O write command, active low |
| mrdc_n_o | output | 1 | Memory read command, active low |
| mwtc_n_o | output | 1 | Memory write command, active low |
| smrdc_n_o | output | 1 | Standard memory read, first megabyte, active low |
| smwtc_n_o | output | 1 | Standard memory write, first megabyte, active low |
| nows_n_i | input | 1 | No-wait-state request from slave, active low |
| chrdy_i | input | 1 | Channel ready from slave, low = extend |

## Verification
The bench builds the block with WAIT_STATES = 2, ADDR_W = 32, SA_W = 20 and LOW_MEG_BITS = 20. The short timer keeps each command at three clocks. With that, a no-wait-state pulse at command clock 0 or 1 clearly cuts the command short, and a channel-ready hold of five clocks clearly outlasts the timer. The 20-bit megabyte boundary lets addresses 0x000FFFFF and 0x00100000 land on either side of the standard-memory decode.

// File: rtl/isa_cg_pkg.sv
package isa_cg_pkg;

  // sequencing phases of one bus cycle
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_LATCH = 3'd2,
    PH_CMD   = 3'd3,
    PH_DONE  = 3'd4
  } phase_e;

  // command kind, encoded as {memory, write}
  typedef enum logic [1:0] {
    CK_IO_RD  = 2'b00,
    CK_IO_WR  = 2'b01,
    CK_MEM_RD = 2'b10,
    CK_MEM_WR = 2'b11
  } cmd_kind_e;

  // strobe vector positions (active high inside the block)
  localparam int unsigned STB_N      = 6;
  localparam int unsigned STB_IO_RD  = 5;
  localparam int unsigned STB_IO_WR  = 4;
  localparam int unsigned STB_MEM_RD = 3;
  localparam int unsigned STB_MEM_WR = 2;
  localparam int unsigned STB_STD_RD = 1;
  localparam int unsigned STB_STD_WR = 0;

  function automatic cmd_kind_e pick_kind(input logic is_mem, input logic is_write);
    return cmd_kind_e'({is_mem, is_write});
  endfunction

  // true when no address bit at or above lim_bits is set
  function automatic logic below_limit(input logic [63:0] addr, input int unsigned lim_bits);
    logic [63:0] upper;
    upper = addr >> lim_bits;
    return (upper == 64'd0);
  endfunction

  // which strobes a cycle of this kind raises during data time
  function automatic logic [STB_N-1:0] strobe_set(input cmd_kind_e kind, input logic low_meg);
    logic [STB_N-1:0] s;
    s = '0;
    unique case (kind)
      CK_IO_RD:  s[STB_IO_RD] = 1'b1;
      CK_IO_WR:  s[STB_IO_WR] = 1'b1;
      CK_MEM_RD: begin
        s[STB_MEM_RD] = 1'b1;
        s[STB_STD_RD] = low_meg;
      end
      CK_MEM_WR: begin
        s[STB_MEM_WR] = 1'b1;
        s[STB_STD_WR] = low_meg;
      end
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/isa_cg_seq.sv
module isa_cg_seq
  import isa_cg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   finish_i,
  output phase_e phase_o,
  output logic   accept_o,
  output logic   cmd_load_o
);

  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (start_i) phase_d = PH_ADDR;
      PH_ADDR:  phase_d = PH_LATCH;
      PH_LATCH: phase_d = PH_CMD;
      PH_CMD:   if (finish_i) phase_d = PH_DONE;
      PH_DONE:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o    = phase_q;
  assign accept_o   = (phase_q == PH_IDLE) && start_i;
  assign cmd_load_o = (phase_q == PH_LATCH);

endmodule

// File: rtl/isa_cg_timer.sv
module isa_cg_timer #(
  parameter int unsigned WAIT_STATES = 4,
  parameter int unsigned CNT_W       = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic active_i,
  input  logic nows_n_i,
  input  logic chrdy_i,
  output logic expire_o,
  output logic finish_o
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_STATES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (load_i)                      cnt_q <= LOAD_VAL;
    else if (active_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  // timer reaches zero on command clock WAIT_STATES; channel ready gates every end
  assign expire_o = (cnt_q == '0);
  assign finish_o = active_i && chrdy_i && (expire_o || !nows_n_i);

endmodule

// File: rtl/isa_cg_addr.sv
module isa_cg_addr
  import isa_cg_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned SA_W         = 20,
  parameter int unsigned LOW_MEG_BITS = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              latch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              mem_i,
  output logic [SA_W-1:0]   sa_o,
  output cmd_kind_e         kind_o,
  output logic              low_meg_o
);

  logic [SA_W-1:0] sa_cur_q;
  logic [SA_W-1:0] sa_hold_q;
  cmd_kind_e       kind_q;
  logic            low_meg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sa_cur_q  <= '0;
      kind_q    <= CK_IO_RD;
      low_meg_q <= 1'b0;
    end else if (accept_i) begin
      sa_cur_q  <= addr_i[SA_W-1:0];
      kind_q    <= pick_kind(mem_i, write_i);
      low_meg_q <= below_limit(64'(addr_i), LOW_MEG_BITS);
    end
  end

  // hold register closes when the latch enable drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sa_hold_q <= '0;
    else if (latch_i) sa_hold_q <= sa_cur_q;
  end

  assign sa_o      = latch_i ? sa_cur_q : sa_hold_q;
  assign kind_o    = kind_q;
  assign low_meg_o = low_meg_q;

endmodule

// File: rtl/isa_cg_strobes.sv
module isa_cg_strobes
  import isa_cg_pkg::*;
(
  input  logic             cmd_live_i,
  input  cmd_kind_e        kind_i,
  input  logic             low_meg_i,
  output logic [STB_N-1:0] strobe_n_o
);

  logic [STB_N-1:0] sel;

  assign sel = strobe_set(kind_i, low_meg_i);

  for (genvar g = 0; g < STB_N; g++) begin : g_stb
    assign strobe_n_o[g] = ~(cmd_live_i & sel[g]);
  end

endmodule

// File: rtl/isa_cycle_gen.sv
module isa_cycle_gen
  import isa_cg_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned SA_W         = 20,
  parameter int unsigned LOW_MEG_BITS = 20,
  parameter int unsigned WAIT_STATES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              mem_i,
  output logic              ready_o,
  output logic              bale_o,
  output logic [SA_W-1:0]   sa_o,
  output logic              iorc_n_o,
  output logic              iowc_n_o,
  output logic              mrdc_n_o,
  output logic              mwtc_n_o,
  output logic              smrdc_n_o,
  output logic              smwtc_n_o,
  input  logic              nows_n_i,
  input  logic              chrdy_i
);

  localparam int unsigned CNT_W = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);

  // named internal events, observed by the bound checker
  phase_e           phase;
  logic             accept;
  logic             cmd_load;
  logic             cmd_live;
  logic             tmr_expire;
  logic             cyc_finish;
  cmd_kind_e        kind;
  logic             low_meg;
  logic [STB_N-1:0] strobe_n;

  isa_cg_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .finish_i   (cyc_finish),
    .phase_o    (phase),
    .accept_o   (accept),
    .cmd_load_o (cmd_load)
  );

  assign cmd_live = (phase == PH_CMD);

  isa_cg_timer #(
    .WAIT_STATES (WAIT_STATES),
    .CNT_W       (CNT_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cmd_load),
    .active_i (cmd_live),
    .nows_n_i (nows_n_i),
    .chrdy_i  (chrdy_i),
    .expire_o (tmr_expire),
    .finish_o (cyc_finish)
  );

  isa_cg_addr #(
    .ADDR_W       (ADDR_W),
    .SA_W         (SA_W),
    .LOW_MEG_BITS (LOW_MEG_BITS)
  ) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .latch_i   (cmd_load),
    .addr_i    (addr_i),
    .write_i   (write_i),
    .mem_i     (mem_i),
    .sa_o      (sa_o),
    .kind_o    (kind),
    .low_meg_o (low_meg)
  );

  isa_cg_strobes u_stb (
    .cmd_live_i (cmd_live),
    .kind_i     (kind),
    .low_meg_i  (low_meg),
    .strobe_n_o (strobe_n)
  );

  assign bale_o    = (phase == PH_LATCH);
  assign ready_o   = (phase == PH_DONE);
  assign iorc_n_o  = strobe_n[STB_IO_RD];
  assign iowc_n_o  = strobe_n[STB_IO_WR];
  assign mrdc_n_o  = strobe_n[STB_MEM_RD];
  assign mwtc_n_o  = strobe_n[STB_MEM_WR];
  assign smrdc_n_o = strobe_n[STB_STD_RD];
  assign smwtc_n_o = strobe_n[STB_STD_WR];

endmodule

// File: rtl/isa_cycle_gen_chk.sv
module isa_cycle_gen_chk #(
  parameter int unsigned SA_W        = 20,
  parameter int unsigned WAIT_STATES = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ready_o,
  input logic            bale_o,
  input logic [SA_W-1:0] sa_o,
  input logic            iorc_n_o,
  input logic            iowc_n_o,
  input logic            mrdc_n_o,
  input logic            mwtc_n_o,
  input logic            smrdc_n_o,
  input logic            smwtc_n_o,
  input logic            nows_n_i,
  input logic            chrdy_i,
  input logic            cmd_live,
  input logic            cyc_finish
);

  logic [3:0] main_act;
  logic       any_act;
  logic [15:0] cmd_idx;

  assign main_act = ~{iorc_n_o, iowc_n_o, mrdc_n_o, mwtc_n_o};
  assign any_act  = (main_act != 4'd0) || !smrdc_n_o || !smwtc_n_o;

  // index of the current command clock, counted from 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cmd_idx <= '0;
    else if (!cmd_live)                cmd_idx <= '0;
    else if (cmd_idx != 16'hFFFF)      cmd_idx <= cmd_idx + 1'b1;
  end

  assert_bale_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bale_o |=> !bale_o);
  assert_bale_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bale_o |-> !any_act);
  assert_sa_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bale_o |-> $stable(sa_o));
  assert_one_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(main_act));
  assert_cmd_in_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_live |-> $countones(main_act) == 1);
  assert_std_rd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smrdc_n_o |-> !mrdc_n_o);
  assert_std_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smwtc_n_o |-> !mwtc_n_o);
  assert_no_early_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_live && nows_n_i && (32'(cmd_idx) < WAIT_STATES)) |=> !ready_o);
  assert_timeout_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_live && chrdy_i && (32'(cmd_idx) >= WAIT_STATES)) |=> ready_o);
  assert_nows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_live && !nows_n_i && chrdy_i) |=> ready_o);
  assert_chrdy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_live && !chrdy_i) |=> (cmd_live && !ready_o));
  assert_finish_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_finish |=> ready_o);
  assert_ready_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  assert_ready_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !any_act);

endmodule

bind isa_cycle_gen isa_cycle_gen_chk #(
  .SA_W        (SA_W),
  .WAIT_STATES (WAIT_STATES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_o    (ready_o),
  .bale_o     (bale_o),
  .sa_o       (sa_o),
  .iorc_n_o   (iorc_n_o),
  .iowc_n_o   (iowc_n_o),
  .mrdc_n_o   (mrdc_n_o),
  .mwtc_n_o   (mwtc_n_o),
  .smrdc_n_o  (smrdc_n_o),
  .smwtc_n_o  (smwtc_n_o),
  .nows_n_i   (nows_n_i),
  .chrdy_i    (chrdy_i),
  .cmd_live   (cmd_live),
  .cyc_finish (cyc_finish)
);

// File: tb/sim_isa_cycle_gen.sv
`timescale 1ns/1ps
module sim_isa_cycle_gen;

  localparam int W    = 2;
  localparam int AW   = 32;
  localparam int SAW  = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic          mem = 1'b0;
  logic          nows_n = 1'b1;
  logic          chrdy = 1'b1;
  logic          ready, bale;
  logic [SAW-1:0] sa;
  logic          iorc_n, iowc_n, mrdc_n, mwtc_n, smrdc_n, smwtc_n;

  always #10 clk = ~clk;

  isa_cycle_gen #(
    .ADDR_W(AW), .SA_W(SAW), .LOW_MEG_BITS(20), .WAIT_STATES(W)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .write_i(wr), .mem_i(mem), .ready_o(ready), .bale_o(bale), .sa_o(sa),
    .iorc_n_o(iorc_n), .iowc_n_o(iowc_n), .mrdc_n_o(mrdc_n), .mwtc_n_o(mwtc_n),
    .smrdc_n_o(smrdc_n), .smwtc_n_o(smwtc_n), .nows_n_i(nows_n), .chrdy_i(chrdy)
  );

  typedef struct {
    int       sa;
    bit [5:0] vec;
    int       len;
    string    req;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   bale_total = 0;
  bit   done = 0;

  function automatic bit [5:0] strobes_now();
    return {iorc_n, iowc_n, mrdc_n, mwtc_n, smrdc_n, smwtc_n};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // expected active-low vector, order {io rd, io wr, mem rd, mem wr, std rd, std wr}
  function automatic bit [5:0] exp_vec(input bit m, input bit w, input logic [AW-1:0] a);
    bit [5:0] v = 6'b111111;
    bit low = (a < 32'h0010_0000);
    case ({m, w})
      2'b00: v[5] = 1'b0;
      2'b01: v[4] = 1'b0;
      2'b10: begin v[3] = 1'b0; if (low) v[1] = 1'b0; end
      default: begin v[2] = 1'b0; if (low) v[0] = 1'b0; end
    endcase
    return v;
  endfunction

  // command length: first clock n with channel ready high and (n >= W or no-wait at n)
  function automatic int exp_len(input int nows_at, input int hold);
    for (int n = 0; n < 1000; n++)
      if (n >= hold && (n == nows_at || n >= W)) return n + 1;
    return -1;
  endfunction

  // driver: pushes the expected item and plays the slave side
  task automatic run_cycle(input logic [AW-1:0] a, input bit w, input bit m,
                           input int nows_at, input int hold, input bit poke,
                           input string req);
    exp_t e;
    int   guard;
    int   n;
    e.sa  = int'(a[SAW-1:0]);
    e.vec = exp_vec(m, w, a);
    e.len = exp_len(nows_at, hold);
    e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b1; addr = a; wr = w; mem = m;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (strobes_now() == 6'b111111 && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    n = 0;
    while (strobes_now() != 6'b111111 && n < 200) begin
      chrdy  = (n < hold) ? 1'b0 : 1'b1;
      nows_n = (n == nows_at) ? 1'b0 : 1'b1;
      if (poke && n == 0) begin
        start = 1'b1; addr = 32'h0000_0ABC; wr = ~w; mem = ~m;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    chrdy = 1'b1; nows_n = 1'b1;
    if (poke) begin
      start = 1'b1; addr = 32'h0000_0DEF;   // lands in the ready clock
      @(negedge clk);
      start = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  // monitor: observes the ports and compares with the queue
  int       cur_len = 0;
  int       bale_run = 0;
  int       sa_bale = 0;
  bit [5:0] cur_vec = 6'b111111;
  bit       prev_ready = 0;
  bit       prev_cmd = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [5:0] v;
      v = strobes_now();
      if (bale) begin
        bale_total++;
        bale_run++;
        sa_bale = int'(sa);
        check(v == 6'b111111, "R2", "strobes during latch enable", v, 6'h3F);
        check(exp_q.size() > 0, "R10", "latch enable with nothing pending", 0, 1);
      end
      if (v != 6'b111111) begin
        if (cur_len == 0) cur_vec = v;
        else check(v == cur_vec, "R4", "strobe changed within command", v, cur_vec);
        check(int'(sa) == sa_bale, "R3", "address held after latch", sa, sa_bale);
        cur_len++;
      end
      if (ready) begin
        exp_t e;
        check(!prev_ready, "R9", "ready longer than one clock", 1, 0);
        check(prev_cmd, "R9", "ready not right after command", 0, 1);
        check(v == 6'b111111, "R9", "strobes during ready", v, 6'h3F);
        if (exp_q.size() == 0) begin
          check(0, "R10", "ready with nothing pending", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check(cur_vec == e.vec, {e.req, " R4/R5"}, "strobe pattern", cur_vec, e.vec);
          check(cur_len == e.len, e.req, "command length", cur_len, e.len);
          check(sa_bale == e.sa, {e.req, " R3"}, "latched address", sa_bale, e.sa);
          check(bale_run == 1, {e.req, " R2"}, "latch enable clocks", bale_run, 1);
        end
        cur_len = 0;
        bale_run = 0;
        cur_vec = 6'b111111;
      end
      prev_ready = ready;
      prev_cmd   = (v != 6'b111111);
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int bale_before;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(strobes_now() == 6'b111111, "R1", "strobes in reset", strobes_now(), 6'h3F);
    check(bale == 1'b0, "R1", "latch enable in reset", bale, 0);
    check(ready == 1'b0, "R1", "ready in reset", ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 / R6: the four kinds with the default timer
    run_cycle(32'h0000_03F8, 1'b0, 1'b0, -1, 0, 0, "R4 R6 io-rd");
    run_cycle(32'h0000_0080, 1'b1, 1'b0, -1, 0, 0, "R4 R6 io-wr");
    // R5: first-megabyte decode and its boundary
    run_cycle(32'h000C_8000, 1'b0, 1'b1, -1, 0, 0, "R5 mem-rd low");
    run_cycle(32'h000F_FFFF, 1'b1, 1'b1, -1, 0, 0, "R5 mem-wr top of megabyte");
    run_cycle(32'h0010_0000, 1'b0, 1'b1, -1, 0, 0, "R5 mem-rd above megabyte");
    run_cycle(32'h1234_5678, 1'b1, 1'b1, -1, 0, 0, "R5 mem-wr high");
    // R7: no-wait-state cuts the command short
    run_cycle(32'h0000_0300, 1'b0, 1'b0, 0, 0, 0, "R7 nows at clock 0");
    run_cycle(32'h000A_0000, 1'b1, 1'b1, 1, 0, 0, "R7 nows at clock 1");
    // R8: channel ready extends past the timer, and blocks no-wait-state
    run_cycle(32'h000B_1234, 1'b0, 1'b1, -1, 5, 0, "R8 chrdy low 5");
    run_cycle(32'h0000_0278, 1'b1, 1'b0, 2, 5, 0, "R8 nows while chrdy low");
    run_cycle(32'h0200_0010, 1'b0, 1'b1, 1, 1, 0, "R8 nows after short hold");
    // R10: starts during the command and during ready are ignored
    bale_before = bale_total;
    run_cycle(32'h0005_5555, 1'b1, 1'b1, -1, 0, 1, "R10 start while busy");
    repeat (6) @(negedge clk);
    check(bale_total == bale_before + 1, "R10", "latch enables for one request",
          bale_total - bale_before, 1);
    check(exp_q.size() == 0, "R10", "pending items left", exp_q.size(), 0);
    check(ready == 1'b0 && strobes_now() == 6'b111111, "R10", "idle after ignored start",
          {ready, strobes_now()}, 7'h3F);
    // R3: address outputs hold between cycles
    check(int'(sa) == 32'h5_5555, "R3", "address held while idle", sa, 32'h5_5555);

    done = 1;
    summary();
    $finish;
  end

endmodule